// File: doc/BRIEF.md
# Sample Stream Alignment Shifter

This block re-times a stream of packed 8-bit samples so that a chosen sample, normally the one at which a trigger fired, lands in byte lane 0 of the first output word. Samples arrive as 64-bit words holding eight samples each. Lane 0 (bits [7:0]) holds the earliest sample of the word, and the sample stream continues from lane 7 of one word into lane 0 of the next.

A start strobe loads a 5-bit offset. Its upper two bits give the number of whole words to drop from the head of the stream. Its lower three bits give the number of byte lanes by which the data is shifted toward lane 0. The shift is built from two adjacent words: a one-word history register and the word now arriving. It needs no arithmetic, only byte selection.

Both stream sides use valid/ready handshakes. Output back-pressure holds the input side, so no sample is lost or repeated.

Top module: `sample_align`

## Requirements
- R1: After reset, and until the first start strobe, `m_valid` is 0 and `s_ready` is 0.
- R2: In a cycle where `align_go` is 1, `s_ready` is 0, so no input word is taken. In the next cycle `m_valid` is 0, and any output word still held is dropped.
- R3: After a start, the first D accepted input words are discarded, where D = `align_ofs[4:3]` (0 to 3). During the discard phase and the following fill word, `s_ready` is 1.
- R4: `m_valid` stays 0 until D+2 input words have been accepted since the start. Output word k (counting from 0) is delivered while exactly D+k+2 words have been accepted.
- R5: With B = `align_ofs[2:0]`, output word k lane j (bits [8j+7:8j]) equals stream byte 8·(D+k)+B+j. The stream byte index counts input lanes from lane 0 of the first input word after the start.
- R6: With B = 0, each output word equals the input word accepted one word earlier.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` stays unchanged in the next cycle.
- R8: A new output word is loaded only when the output register is empty or its word is being taken in the same cycle. Every stream byte therefore appears once, in order.
- R9: Once the fill word is taken, `s_ready` equals `!m_valid || m_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| align_go | input | 1 | Start strobe; loads `align_ofs` and restarts alignment |
| align_ofs | input | 5 | [4:3] words to discard, [2:0] byte-lane shift |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted when high with `s_valid` |
| s_data | input | 64 | Eight packed samples, lane 0 earliest |
| m_valid | output | 1 | Aligned output word valid |
| m_ready | input | 1 | Downstream accepts output word |
| m_data | output | 64 | Aligned output word |

## Verification
A start strobe can arrive in the same cycle that an input word is offered and an earlier output word is still waiting. Each table entry in the bench begins this way. The previous run leaves a word held on the output, `s_valid` is high, and `align_go` is pulsed. The bench requires `s_ready` to be low in that cycle and `m_valid` to be low one cycle later. Only after that does it count the D discarded words and check the byte contents and position of every new output word.

// File: rtl/sa_pkg.sv
package sa_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SKIP = 2'd1,
      ST_FILL = 2'd2,
      ST_RUN  = 2'd3
   } sa_state_e;
endpackage

// File: rtl/sa_skip_ctrl.sv
module sa_skip_ctrl
   import sa_pkg::*;
#(
   parameter int MAX_SKIP = 3,
   parameter int SKIP_W   = 2,
   parameter int ROT_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [SKIP_W-1:0] skip_i,
   input  logic [ROT_W-1:0]  rot_i,
   input  logic              take_i,
   output sa_state_e         state_o,
   output logic [ROT_W-1:0]  rot_o
);
   if (MAX_SKIP < 1) begin : g_chk_skip
      $error("MAX_SKIP must be at least 1");
   end
   if ((1 << SKIP_W) <= MAX_SKIP) begin : g_chk_skipw
      $error("SKIP_W too narrow for MAX_SKIP");
   end

   localparam logic [SKIP_W-1:0] SKIP_CAP = SKIP_W'(MAX_SKIP);

   sa_state_e         state_q;
   logic [SKIP_W-1:0] cnt_q;
   logic [ROT_W-1:0]  rot_q;
   logic [SKIP_W-1:0] skip_eff;

   assign skip_eff = (skip_i > SKIP_CAP) ? SKIP_CAP : skip_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rot_q   <= '0;
      end else if (go_i) begin
         state_q <= (skip_eff != '0) ? ST_SKIP : ST_FILL;
         cnt_q   <= skip_eff;
         rot_q   <= rot_i;
      end else if (take_i) begin
         unique case (state_q)
            ST_SKIP: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == SKIP_W'(1)) state_q <= ST_FILL;
            end
            ST_FILL: state_q <= ST_RUN;
            default: state_q <= state_q;
         endcase
      end
   end

   assign state_o = state_q;
   assign rot_o   = rot_q;

   AST_SKIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= SKIP_CAP);  // R3
   AST_SKIP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP && take_i && !go_i && cnt_q == SKIP_W'(1))
      |=> state_q == ST_FILL);  // R3
   AST_FILL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FILL && take_i && !go_i) |=> state_q == ST_RUN);  // R4
endmodule

// File: rtl/sa_byte_rot.sv
module sa_byte_rot #(
   parameter int SAMPLE_W  = 8,
   parameter int LANES     = 8,
   parameter bit SHIFT_ROT = 1'b0,
   parameter int ROT_W     = $clog2(LANES),
   parameter int WORD_W    = SAMPLE_W * LANES
) (
   input  logic [WORD_W-1:0] prev_i,
   input  logic [WORD_W-1:0] cur_i,
   input  logic [ROT_W-1:0]  rot_i,
   output logic [WORD_W-1:0] word_o
);
   if ((1 << ROT_W) != LANES) begin : g_chk_lanes
      $error("LANES must be a power of two");
   end

   if (SHIFT_ROT) begin : g_shift
      localparam int SHW = $clog2(2 * WORD_W);
      logic [2*WORD_W-1:0] cat;
      logic [2*WORD_W-1:0] shifted;
      logic [SHW-1:0]      shamt;
      assign cat     = {cur_i, prev_i};
      assign shamt   = SHW'(rot_i) * SHW'(SAMPLE_W);
      assign shifted = cat >> shamt;
      assign word_o  = shifted[WORD_W-1:0];
   end else begin : g_mux
      localparam int IDX_W = ROT_W + 1;
      logic [SAMPLE_W-1:0] cat_b [2*LANES];
      for (genvar i = 0; i < LANES; i++) begin : g_fill
         assign cat_b[i]         = prev_i[i*SAMPLE_W +: SAMPLE_W];
         assign cat_b[i + LANES] = cur_i[i*SAMPLE_W +: SAMPLE_W];
      end
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         logic [SAMPLE_W-1:0] pick;
         always_comb pick = cat_b[IDX_W'(j) + IDX_W'(rot_i)];
         assign word_o[j*SAMPLE_W +: SAMPLE_W] = pick;
      end
   end
endmodule

// File: rtl/sa_out_reg.sv
module sa_out_reg #(
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              load_i,
   input  logic              push_i,
   input  logic [WORD_W-1:0] in_word_i,
   input  logic [WORD_W-1:0] rot_word_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] data_o,
   output logic [WORD_W-1:0] hist_o
);
   logic              valid_q;
   logic [WORD_W-1:0] data_q;
   logic [WORD_W-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
         hist_q  <= '0;
      end else begin
         if (clear_i)         valid_q <= 1'b0;
         else if (push_i)     valid_q <= 1'b1;
         else if (ready_i)    valid_q <= 1'b0;
         if (push_i)          data_q  <= rot_word_i;
         if (load_i || push_i) hist_q <= in_word_i;
      end
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;
   assign hist_o  = hist_q;

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready_i && !clear_i) |=> (valid_q && $stable(data_q)));  // R7
   AST_CLEAR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !valid_q);  // R2
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (!valid_q || ready_i));  // R8
endmodule

// File: rtl/sample_align.sv
module sample_align
   import sa_pkg::*;
#(
   parameter int  SAMPLE_W  = 8,
   parameter int  LANES     = 8,
   parameter int  MAX_SKIP  = 3,
   parameter bit  SHIFT_ROT = 1'b0,
   localparam int WORD_W    = SAMPLE_W * LANES,
   localparam int ROT_W     = $clog2(LANES),
   localparam int SKIP_W    = $clog2(MAX_SKIP + 1),
   localparam int OFS_W     = SKIP_W + ROT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              align_go,
   input  logic [OFS_W-1:0]  align_ofs,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [WORD_W-1:0] s_data,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [WORD_W-1:0] m_data
);
   if (SAMPLE_W < 1 || LANES < 2) begin : g_chk_geom
      $error("SAMPLE_W must be >= 1 and LANES >= 2");
   end

   sa_state_e         state;
   logic [ROT_W-1:0]  rot;
   logic [WORD_W-1:0] hist;
   logic [WORD_W-1:0] rot_word;
   logic              take;
   logic              out_free;

   assign out_free = !m_valid || m_ready;
   always_comb begin
      unique case (state)
         ST_SKIP, ST_FILL: s_ready = !align_go;
         ST_RUN:           s_ready = !align_go && out_free;
         default:          s_ready = 1'b0;
      endcase
   end
   assign take = s_valid && s_ready;

   sa_skip_ctrl #(
      .MAX_SKIP (MAX_SKIP),
      .SKIP_W   (SKIP_W),
      .ROT_W    (ROT_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (align_go),
      .skip_i  (align_ofs[OFS_W-1:ROT_W]),
      .rot_i   (align_ofs[ROT_W-1:0]),
      .take_i  (take),
      .state_o (state),
      .rot_o   (rot)
   );

   sa_byte_rot #(
      .SAMPLE_W  (SAMPLE_W),
      .LANES     (LANES),
      .SHIFT_ROT (SHIFT_ROT)
   ) u_rot (
      .prev_i (hist),
      .cur_i  (s_data),
      .rot_i  (rot),
      .word_o (rot_word)
   );

   sa_out_reg #(
      .WORD_W (WORD_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (align_go),
      .load_i     (take && state == ST_FILL),
      .push_i     (take && state == ST_RUN),
      .in_word_i  (s_data),
      .rot_word_i (rot_word),
      .ready_i    (m_ready),
      .valid_o    (m_valid),
      .data_o     (m_data),
      .hist_o     (hist)
   );

   AST_ZERO_ROT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && state == ST_RUN && rot == '0) |=> m_data == $past(hist));  // R6
   AST_OUT_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_valid) |-> $past(state) == ST_RUN);  // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> (!m_valid && !take));  // R1
endmodule

// File: tb/sample_align_tb.sv
module sample_align_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        align_go = 1'b0;
   logic [4:0]  align_ofs = '0;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [63:0] s_data = '0;
   logic        m_valid;
   logic        m_ready = 1'b0;
   logic [63:0] m_data;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   sample_align u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .align_go  (align_go),
      .align_ofs (align_ofs),
      .s_valid   (s_valid),
      .s_ready   (s_ready),
      .s_data    (s_data),
      .m_valid   (m_valid),
      .m_ready   (m_ready),
      .m_data    (m_data)
   );

   // offset[20:16], output count[15:8], ready mask[7:0]
   localparam logic [20:0] VEC [8] = '{
      {5'b00_000, 8'd5, 8'hFF},   // R6 pass-through
      {5'b00_011, 8'd5, 8'hFF},   // R5
      {5'b01_101, 8'd6, 8'hFF},   // R3 R5
      {5'b10_111, 8'd5, 8'hFF},   // R3 R5
      {5'b11_001, 8'd6, 8'hA6},   // R7 R8
      {5'b11_111, 8'd4, 8'h81},   // R7 R8
      {5'b01_000, 8'd6, 8'h5B},   // R6 R7
      {5'b10_100, 8'd5, 8'hF0}    // R5 R9
   };

   function automatic logic [7:0] sb(int n);
      return 8'(n * 37 + 11);
   endfunction

   function automatic logic [63:0] in_word(int k);
      logic [63:0] w;
      for (int i = 0; i < 8; i++) w[i*8 +: 8] = sb(k * 8 + i);
      return w;
   endfunction

   function automatic logic [63:0] exp_word(int d, int b, int k);
      logic [63:0] w;
      for (int j = 0; j < 8; j++) w[j*8 +: 8] = sb((d + k) * 8 + b + j);
      return w;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      s_valid = 1'b1;
      s_data  = in_word(0);
      #1;
      chk("R1 s_ready in reset", 64'(s_ready), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk("R1 s_ready idle", 64'(s_ready), 64'd0);
      chk("R1 m_valid idle", 64'(m_valid), 64'd0);

      for (int v = 0; v < 8; v++) begin
         logic [4:0] ofs;
         int d, b, nout, widx, ocnt, cyc;
         logic [7:0] mask;
         logic held;
         logic [63:0] held_data;
         ofs  = VEC[v][20:16];
         nout = int'(VEC[v][15:8]);
         mask = VEC[v][7:0];
         d    = int'(ofs[4:3]);
         b    = int'(ofs[2:0]);
         // R2: start meets an offered word and a possibly held output
         @(negedge clk);
         align_go  = 1'b1;
         align_ofs = ofs;
         s_valid   = 1'b1;
         s_data    = in_word(0);
         m_ready   = 1'b0;
         #1;
         chk("R2 s_ready low on start", 64'(s_ready), 64'd0);
         widx = 0; ocnt = 0; cyc = 0; held = 1'b0; held_data = '0;
         while (ocnt < nout && cyc < 400) begin
            @(negedge clk);
            if (cyc == 0) begin
               align_go = 1'b0;
               #1;
               chk("R2 output dropped after start", 64'(m_valid), 64'd0);
            end
            m_ready = mask[cyc % 8];
            s_data  = in_word(widx);
            #1;
            if (held) begin
               chk("R7 valid held", 64'(m_valid), 64'd1);
               chk("R7 data held", m_data, held_data);
            end
            if (widx < d + 1)
               chk("R3 ready in skip/fill", 64'(s_ready), 64'd1);
            else
               chk("R9 ready in run", 64'(s_ready), 64'(!m_valid || m_ready));
            if (widx < d + 2)
               chk("R4 no output before fill", 64'(m_valid), 64'd0);
            held = m_valid && !m_ready;
            held_data = m_data;
            if (m_valid && m_ready) begin
               chk("R5 aligned data", m_data, exp_word(d, b, ocnt));
               chk("R4 R8 word position", 64'(widx), 64'(d + ocnt + 2));
               if (b == 0) chk("R6 pass-through", m_data, in_word(d + ocnt));
               ocnt++;
            end
            if (s_ready) widx++;
            cyc++;
         end
         chk("R8 all outputs delivered", 64'(ocnt), 64'(nout));
      end

      // R1: reset while a word is held
      @(negedge clk);
      m_ready = 1'b0;
      s_valid = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 m_valid cleared by reset", 64'(m_valid), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1 idle after reset", 64'(s_ready), 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule